// File: doc/BRIEF.md
# Timer Counter with Side-Effect Flag Clearing

This block is a free-running 16-bit timer counter with the event flags that sit around it: an overflow flag raised when the counter wraps, one flag per capture/compare channel (eight channels), and two pulse accumulator flags. Everything is reached through a byte-wide register bus with a six-bit address. The capture and compare datapaths and the accumulator counter are not part of the block. They only deliver one-cycle strobes that raise their flags. Reads of their data registers return zero here, but the accesses still matter for flag clearing.

Flags can be cleared in two ways, chosen by a control bit. In normal mode, software writes a one to a flag bit to clear it. In fast mode, ordinary accesses to the data registers linked to a flag clear that flag as a side effect, which saves the separate clear write. A freeze input, together with a freeze-stop control bit, can halt the main counter while the accumulator flags keep working.

Top module: `cnt_flag_timer`

## Requirements
- R1: After reset the counter advances by one every clock while not halted. Its high byte reads at offset 0x04 and its low byte at offset 0x05.
- R2: The control register at offset 0x06 has freeze-stop at bit 0 and fast-clear at bit 1. With freeze-stop set and `freeze` high, the counter holds its value. With freeze-stop clear, the counter keeps running while `freeze` is high.
- R3: The overflow flag (offset 0x0F, bit 7) sets in the clock where the counter wraps from 0xFFFF to 0x0000.
- R4: A pulse on `chanEvt[n]` sets channel flag n (offset 0x0E, bit n). `accOvfEvt` sets the accumulator overflow flag and `accInEvt` sets the accumulator input flag (offset 0x21, bits 1 and 0). The accumulator flags are set this way regardless of `freeze` and freeze-stop.
- R5: With fast-clear at 0, a flag clears only when a one is written to its bit in its flag register. Zero bits written leave flags unchanged, and data-register accesses clear nothing.
- R6: With fast-clear at 1 and mode bit n at 0 (capture), a read of offset 0x10+2n or 0x11+2n clears channel flag n. The mode register is at offset 0x07, one bit per channel.
- R7: With fast-clear at 1 and mode bit n at 1 (compare), a write to offset 0x10+2n or 0x11+2n clears channel flag n. The other kind of access (a write to a capture channel or a read of a compare channel) leaves the flag set.
- R8: With fast-clear at 1, any read or write of offset 0x04 or 0x05 clears the overflow flag.
- R9: With fast-clear at 1, any read or write of offset 0x22 or 0x23 clears both accumulator flags.
- R10: With fast-clear at 1, writes to the flag registers (0x0E, 0x0F, 0x21) have no effect on the flags.
- R11: When a set strobe and a clear for the same flag fall in the same clock, the flag ends up set.
- R12: Reset (active-low `rst_n`, asynchronous) clears the counter, the control and mode registers and all flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freeze | input | 1 | Debug halt request; stops the counter when freeze-stop is set |
| busAddr | input | 6 | Register byte address |
| busRd | input | 1 | Read access strobe for this cycle |
| busWr | input | 1 | Write access strobe for this cycle |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for `busAddr` (combinational) |
| chanEvt | input | 8 | Per-channel capture/compare event strobes |
| accOvfEvt | input | 1 | Accumulator overflow event strobe |
| accInEvt | input | 1 | Accumulator input edge event strobe |
| cntVal | output | 16 | Current counter value |

## Verification
The hardest case to reach is an overflow flag raised while fast-clear is on, followed by its side-effect clear through a counter-byte access. Each wrap takes 65,536 unhalted cycles, and the counter cannot be loaded from the bus. The stimulus therefore idles through two full wraps: one in normal mode for the write-one clear and one in fast mode for the access clear. The freeze phases before them shift the wrap point, and the bench's reference model tracks that shift. The same-cycle races, where a set strobe lands in the same clock as a capture read or a write-one clear, are produced by driving the event strobe and the bus access on one clock edge.

// File: rtl/tfc_pkg.sv
package tfc_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam int NCH    = 8;

  localparam logic [ADDR_W-1:0] OFS_CNT_HI  = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_CNT_LO  = 6'h05;
  localparam logic [ADDR_W-1:0] OFS_CTRL    = 6'h06;
  localparam logic [ADDR_W-1:0] OFS_MODE    = 6'h07;
  localparam logic [ADDR_W-1:0] OFS_CHFLG   = 6'h0E;
  localparam logic [ADDR_W-1:0] OFS_MISCFLG = 6'h0F;
  localparam logic [ADDR_W-1:0] OFS_CHDAT   = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_ACCFLG  = 6'h21;
  localparam logic [ADDR_W-1:0] OFS_ACCCNT0 = 6'h22;
  localparam logic [ADDR_W-1:0] OFS_ACCCNT1 = 6'h23;

  typedef enum logic [2:0] {
    RD_NONE, RD_CNT_HI, RD_CNT_LO, RD_CTRL, RD_MODE, RD_CHFLG, RD_MISCFLG, RD_ACCFLG
  } rdSel_e;

  typedef struct packed {
    logic           wrCtrl;
    logic           wrMode;
    logic [NCH-1:0] clrChan;
    logic           clrOvf;
    logic [1:0]     clrAcc;   // [1] accumulator overflow, [0] accumulator input
    rdSel_e         rdSel;
  } strobes_t;
endpackage

// File: rtl/tfc_ctrl.sv
module tfc_ctrl
  import tfc_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              fastClr,
  input  logic [NCH-1:0]    chanMode,
  output strobes_t          stb
);
  localparam int SEL_W = $clog2(NCH);
  localparam logic [ADDR_W-SEL_W-2:0] CH_TAG = OFS_CHDAT[ADDR_W-1:SEL_W+1];

  logic anyAccess;
  logic inChanWin;
  logic cntHit;
  logic accCntHit;

  assign anyAccess = busRd | busWr;
  assign inChanWin = (busAddr[ADDR_W-1:SEL_W+1] == CH_TAG);
  assign cntHit    = (busAddr == OFS_CNT_HI) || (busAddr == OFS_CNT_LO);
  assign accCntHit = (busAddr == OFS_ACCCNT0) || (busAddr == OFS_ACCCNT1);

  always_comb begin
    stb = '0;
    unique case (busAddr)
      OFS_CNT_HI:  stb.rdSel = RD_CNT_HI;
      OFS_CNT_LO:  stb.rdSel = RD_CNT_LO;
      OFS_CTRL:    stb.rdSel = RD_CTRL;
      OFS_MODE:    stb.rdSel = RD_MODE;
      OFS_CHFLG:   stb.rdSel = RD_CHFLG;
      OFS_MISCFLG: stb.rdSel = RD_MISCFLG;
      OFS_ACCFLG:  stb.rdSel = RD_ACCFLG;
      default:     stb.rdSel = RD_NONE;
    endcase
    stb.wrCtrl = busWr && (busAddr == OFS_CTRL);
    stb.wrMode = busWr && (busAddr == OFS_MODE);

    if (!fastClr) begin
      if (busWr && (busAddr == OFS_CHFLG))   stb.clrChan = busWdata[NCH-1:0];
      if (busWr && (busAddr == OFS_MISCFLG)) stb.clrOvf  = busWdata[DATA_W-1];
      if (busWr && (busAddr == OFS_ACCFLG))  stb.clrAcc  = busWdata[1:0];
    end else begin
      for (int ch = 0; ch < NCH; ch++) begin
        stb.clrChan[ch] = inChanWin && (busAddr[SEL_W:1] == SEL_W'(ch)) &&
                          (chanMode[ch] ? busWr : busRd);
      end
      stb.clrOvf = anyAccess && cntHit;
      stb.clrAcc = {2{anyAccess && accCntHit}};
    end
  end
endmodule

// File: rtl/tfc_datapath.sv
module tfc_datapath
  import tfc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze,
  input  strobes_t          stb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [NCH-1:0]    chanEvt,
  input  logic              accOvfEvt,
  input  logic              accInEvt,
  output logic [CNT_W-1:0]  cnt,
  output logic              freezeStop,
  output logic              fastClr,
  output logic [NCH-1:0]    chanMode,
  output logic [NCH-1:0]    chanFlags,
  output logic              ovfFlag,
  output logic [1:0]        accFlags,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic run;
  logic ovfSet;
  logic unusedWdata;

  assign unusedWdata = ^busWdata[DATA_W-1:2];
  assign run    = !(freeze && freezeStop);
  assign ovfSet = run && (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      freezeStop <= 1'b0;
      fastClr    <= 1'b0;
      chanMode   <= '0;
      chanFlags  <= '0;
      ovfFlag    <= 1'b0;
      accFlags   <= '0;
    end else begin
      if (run) cnt <= cnt + 1'b1;
      if (stb.wrCtrl) begin
        freezeStop <= busWdata[0];
        fastClr    <= busWdata[1];
      end
      if (stb.wrMode) chanMode <= busWdata[NCH-1:0];
      // set terms are OR-ed after the clear so a coincident event survives
      chanFlags <= (chanFlags & ~stb.clrChan) | chanEvt;
      ovfFlag   <= (ovfFlag & ~stb.clrOvf) | ovfSet;
      accFlags  <= (accFlags & ~stb.clrAcc) | {accOvfEvt, accInEvt};
    end
  end

  always_comb begin
    unique case (stb.rdSel)
      RD_CNT_HI:  rdata = cnt[CNT_W-1 -: DATA_W];
      RD_CNT_LO:  rdata = cnt[DATA_W-1:0];
      RD_CTRL:    rdata = {{(DATA_W-2){1'b0}}, fastClr, freezeStop};
      RD_MODE:    rdata = chanMode;
      RD_CHFLG:   rdata = chanFlags;
      RD_MISCFLG: rdata = {ovfFlag, {(DATA_W-1){1'b0}}};
      RD_ACCFLG:  rdata = {{(DATA_W-2){1'b0}}, accFlags};
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/cnt_flag_timer.sv
module cnt_flag_timer
  import tfc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [NCH-1:0]    chanEvt,
  input  logic              accOvfEvt,
  input  logic              accInEvt,
  output logic [CNT_W-1:0]  cntVal
);
  strobes_t       stb;
  logic           freezeStop;
  logic           fastClr;
  logic [NCH-1:0] chanMode;
  logic [NCH-1:0] chanFlags;
  logic           ovfFlag;
  logic [1:0]     accFlags;

  tfc_ctrl i_ctrl (
    .busAddr (busAddr),
    .busRd   (busRd),
    .busWr   (busWr),
    .busWdata(busWdata),
    .fastClr (fastClr),
    .chanMode(chanMode),
    .stb     (stb)
  );

  tfc_datapath #(.CNT_W(CNT_W)) i_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .freeze    (freeze),
    .stb       (stb),
    .busWdata  (busWdata),
    .chanEvt   (chanEvt),
    .accOvfEvt (accOvfEvt),
    .accInEvt  (accInEvt),
    .cnt       (cntVal),
    .freezeStop(freezeStop),
    .fastClr   (fastClr),
    .chanMode  (chanMode),
    .chanFlags (chanFlags),
    .ovfFlag   (ovfFlag),
    .accFlags  (accFlags),
    .rdata     (busRdata)
  );
endmodule

// File: rtl/tfc_chk.sv
module tfc_chk
  import tfc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              freeze,
  input logic              busWr,
  input logic [CNT_W-1:0]  cntVal,
  input logic              freezeStop,
  input logic              fastClr,
  input logic [NCH-1:0]    chanEvt,
  input logic [NCH-1:0]    chanFlags,
  input logic              ovfFlag,
  input logic [1:0]        accFlags,
  input logic              accOvfEvt,
  input logic              accInEvt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(freeze && freezeStop) |=> cntVal == $past(cntVal) + 1'b1); // R1
  AST_FRZ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && freezeStop) |=> $stable(cntVal)); // R2
  AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cntVal == CNT_MAX && !(freeze && freezeStop)) |=> ovfFlag); // R3
  AST_ACC_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (accOvfEvt || accInEvt) |=> (accFlags[1] || !$past(accOvfEvt)) && (accFlags[0] || !$past(accInEvt))); // R4
  AST_NORMAL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!fastClr && !busWr && ovfFlag) |=> ovfFlag); // R5

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    AST_CH_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      chanEvt[i] |=> chanFlags[i]); // R11
    AST_CH_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chanFlags[i]) |-> $past(chanEvt[i])); // R4
  end
endmodule

bind cnt_flag_timer tfc_chk #(.CNT_W(CNT_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .freeze    (freeze),
  .busWr     (busWr),
  .cntVal    (cntVal),
  .freezeStop(freezeStop),
  .fastClr   (fastClr),
  .chanEvt   (chanEvt),
  .chanFlags (chanFlags),
  .ovfFlag   (ovfFlag),
  .accFlags  (accFlags),
  .accOvfEvt (accOvfEvt),
  .accInEvt  (accInEvt)
);

// File: tb/test_cnt_flag_timer.sv
`timescale 1ns/1ps
module test_cnt_flag_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        freeze = 1'b0;
  logic [5:0]  busAddr = 6'h0E;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busWdata = 8'h00;
  logic [7:0]  busRdata;
  logic [7:0]  chanEvt = 8'h00;
  logic        accOvfEvt = 1'b0;
  logic        accInEvt = 1'b0;
  logic [15:0] cntVal;

  int nChk = 0;
  int nBad = 0;
  int cycles = 0;
  bit done = 0;
  string curReq = "R12";

  // reference model state
  logic [15:0] mCnt;
  logic        mFrz, mFast, mOvf;
  logic [7:0]  mMode, mChan;
  logic [1:0]  mAcc;
  logic [7:0]  clrC;
  logic        clrO;
  logic [1:0]  clrA;
  bit          run;
  int          a;

  always #2 clk = ~clk;  // 250 MHz

  cnt_flag_timer i_cnt_flag_timer (
    .clk(clk), .rst_n(rst_n), .freeze(freeze),
    .busAddr(busAddr), .busRd(busRd), .busWr(busWr), .busWdata(busWdata),
    .busRdata(busRdata), .chanEvt(chanEvt), .accOvfEvt(accOvfEvt),
    .accInEvt(accInEvt), .cntVal(cntVal)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mCnt = 0; mFrz = 0; mFast = 0; mOvf = 0; mMode = 0; mChan = 0; mAcc = 0;
    end else begin
      run = !(freeze && mFrz);
      a = int'(busAddr);
      clrC = 0; clrO = 0; clrA = 0;
      if (mFast) begin
        for (int ch = 0; ch < 8; ch++)
          if (a >= 16 && a < 32 && (a - 16) / 2 == ch)
            clrC[ch] = mMode[ch] ? busWr : busRd;
        if ((busRd || busWr) && (a == 4 || a == 5)) clrO = 1;
        if ((busRd || busWr) && (a == 34 || a == 35)) clrA = 2'b11;
      end else if (busWr) begin
        if (a == 14) clrC = busWdata;
        if (a == 15) clrO = busWdata[7];
        if (a == 33) clrA = busWdata[1:0];
      end
      mChan = (mChan & ~clrC) | chanEvt;
      mAcc  = (mAcc & ~clrA) | {accOvfEvt, accInEvt};
      mOvf  = (mOvf && !clrO) || (run && mCnt == 16'hFFFF);
      if (busWr && a == 6) begin mFrz = busWdata[0]; mFast = busWdata[1]; end
      if (busWr && a == 7) mMode = busWdata;
      if (run) mCnt = mCnt + 1;
    end
  end

  function automatic logic [7:0] expRd(input logic [5:0] ad);
    case (ad)
      6'h04: return mCnt[15:8];
      6'h05: return mCnt[7:0];
      6'h06: return {6'b0, mFast, mFrz};
      6'h07: return mMode;
      6'h0E: return mChan;
      6'h0F: return {mOvf, 7'b0};
      6'h21: return {6'b0, mAcc};
      default: return 8'h00;
    endcase
  endfunction

  always @(negedge clk) begin
    #1;
    if (!done) begin
      nChk += 2;
      if (cntVal !== mCnt) begin
        nBad++;
        $display("FAIL %s counter: actual %h expected %h", curReq, cntVal, mCnt);
      end
      if (busRdata !== expRd(busAddr)) begin
        nBad++;
        $display("FAIL %s read @%h: actual %h expected %h", curReq, busAddr, busRdata, expRd(busAddr));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1;
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  task automatic op(input logic [5:0] ad, input logic r, input logic w,
                    input logic [7:0] d, input logic [7:0] ce, input logic [1:0] ae);
    @(negedge clk);
    busAddr = ad; busRd = r; busWr = w; busWdata = d; chanEvt = ce;
    {accOvfEvt, accInEvt} = ae;
  endtask

  task automatic idle(input int n, input logic [5:0] ad);
    repeat (n) op(ad, 0, 0, 8'h00, 8'h00, 2'b00);
  endtask

  initial begin
    curReq = "R12";
    idle(4, 6'h0E);
    idle(1, 6'h0F);
    idle(1, 6'h21);
    idle(1, 6'h06);
    rst_n = 1'b1;

    curReq = "R1";
    idle(10, 6'h05);
    idle(3, 6'h04);

    curReq = "R2";
    @(negedge clk); freeze = 1'b1;
    idle(5, 6'h05);                      // freeze-stop clear: still running
    op(6'h06, 0, 1, 8'h01, 0, 0);        // freeze-stop on
    idle(6, 6'h05);                      // held
    curReq = "R4";
    op(6'h21, 0, 0, 0, 0, 2'b10);        // accumulator strobes while frozen
    op(6'h21, 0, 0, 0, 0, 2'b01);
    idle(2, 6'h21);
    @(negedge clk); freeze = 1'b0;
    curReq = "R2";
    idle(4, 6'h05);

    curReq = "R4";
    op(6'h0E, 0, 0, 0, 8'hA5, 0);
    op(6'h0E, 0, 0, 0, 8'h5A, 0);
    idle(2, 6'h0E);

    curReq = "R5";
    op(6'h0E, 0, 1, 8'h00, 0, 0);        // zeros: no effect
    idle(1, 6'h0E);
    op(6'h0E, 0, 1, 8'h0F, 0, 0);        // clear low nibble
    idle(1, 6'h0E);
    op(6'h10, 1, 0, 0, 0, 0);            // data read: no clear in normal mode
    op(6'h22, 1, 0, 0, 0, 0);
    idle(1, 6'h21);
    op(6'h21, 0, 1, 8'h02, 0, 0);
    idle(1, 6'h21);

    curReq = "R11";
    op(6'h0E, 0, 1, 8'hF0, 8'h80, 0);    // clear and set bit 7 together
    idle(2, 6'h0E);

    curReq = "R3";
    idle(65600, 6'h0F);
    curReq = "R5";
    op(6'h0F, 0, 1, 8'h7F, 0, 0);        // bit 7 zero: stays
    idle(1, 6'h0F);
    op(6'h0F, 0, 1, 8'h80, 0, 0);
    idle(2, 6'h0F);

    curReq = "R6";
    op(6'h06, 0, 1, 8'h02, 0, 0);        // fast clear on
    op(6'h07, 0, 1, 8'hF0, 0, 0);        // ch4..7 compare
    op(6'h0E, 0, 0, 0, 8'hFF, 0);
    idle(1, 6'h0E);
    op(6'h10, 1, 0, 0, 0, 0);            // ch0 read clears
    idle(1, 6'h0E);
    op(6'h17, 1, 0, 0, 0, 0);            // ch3 odd byte read clears
    idle(1, 6'h0E);
    curReq = "R7";
    op(6'h12, 0, 1, 8'h33, 0, 0);        // write to capture ch1: kept
    idle(1, 6'h0E);
    op(6'h18, 0, 1, 8'h44, 0, 0);        // write to compare ch4: clears
    idle(1, 6'h0E);
    op(6'h1B, 1, 0, 0, 0, 0);            // read compare ch5: kept
    idle(1, 6'h0E);
    op(6'h1F, 0, 1, 8'h01, 0, 0);        // ch7 clears
    idle(1, 6'h0E);

    curReq = "R10";
    op(6'h0E, 0, 1, 8'hFF, 0, 0);
    idle(1, 6'h0E);
    op(6'h21, 0, 0, 0, 0, 2'b11);
    op(6'h21, 0, 1, 8'h03, 0, 0);
    idle(1, 6'h21);

    curReq = "R9";
    op(6'h23, 1, 0, 0, 0, 0);
    idle(1, 6'h21);
    op(6'h21, 0, 0, 0, 0, 2'b11);
    op(6'h22, 0, 1, 8'h00, 0, 0);
    idle(1, 6'h21);

    curReq = "R11";
    op(6'h12, 1, 0, 0, 8'h02, 0);        // capture read of ch1 with ch1 event
    idle(2, 6'h0E);
    op(6'h22, 1, 0, 0, 0, 2'b01);
    idle(1, 6'h21);

    curReq = "R3";
    idle(65600, 6'h0F);
    curReq = "R10";
    op(6'h0F, 0, 1, 8'h80, 0, 0);
    idle(1, 6'h0F);
    curReq = "R8";
    op(6'h05, 1, 0, 0, 0, 0);
    idle(2, 6'h0F);
    op(6'h04, 0, 1, 8'h55, 0, 0);        // write to counter byte: counter unaffected
    idle(2, 6'h05);

    idle(2, 6'h0E);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule